// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is a byte-oriented SPI port that a processor uses to exchange bytes with serial peripherals or with another controller. One shift register sends and receives at the same time, most significant bit first. A separate receive buffer holds the last completed byte for the processor. The processor starts an outgoing byte by writing it. It collects an incoming byte by reading the buffer and pulsing a read strobe.

A 4-bit mode field picks the role. In master mode the port drives the serial clock. The clock comes from an instruction-cycle tick divided by one of three parameterised ratios, or from an external timer pulse. In slave mode the port takes the serial clock in through a two-flop synchroniser. It can optionally obey an active-low select line, which restarts the bit count whenever the select line is high. A polarity bit sets the idle level of the clock. An edge bit chooses the edge on which data is launched and the edge on which it is captured. An enable bit runs the port. Clearing that bit aborts any transfer so the port can be reconfigured.

Top module: `spi_port`

## Requirements
- R1: In master modes (mode 4'b0000 to 4'b0011), a buffer write while no transfer is running starts a transfer of that byte, MSB first. SCK makes exactly 8 cycles and then rests at its idle level. The 8 bits captured from SDI, MSB first, land in the buffer.
- R2: SCK half-period in master mode: 4'b0000 gives 2 ticks of cycTick, 4'b0001 gives 8 ticks and 4'b0010 gives 32 ticks (SCK period of 4, 16 and 64 ticks). In 4'b0011 each timerPulse produces exactly one SCK transition, and SCK does not move without one.
- R3: clkPol is the idle level of SCK. The leading edge is the edge that leaves the idle level, and the trailing edge is the one that returns to it.
- R4: With clkEdge=0, SDO takes each bit on a leading edge and SDI is captured on the trailing edge. With clkEdge=1, the first bit is on SDO before the first leading edge, SDI is captured on leading edges, and SDO changes on trailing edges.
- R5: In slave modes (4'b0100 and 4'b0101), sckIn passes through a two-flop synchroniser. Its edges drive the same launch and capture rules, and a byte written while the slave is between bytes is shifted out on SDO.
- R6: In mode 4'b0100, ssN high resets the bit counter at once and SCK edges are ignored. A partly received byte is discarded and the next byte starts at bit 7.
- R7: In mode 4'b0101 with clkEdge=0, ssN has no effect. In mode 4'b0101 with clkEdge=1, select control is forced on, as in 4'b0100.
- R8: bufFull is set when a received byte is copied into the buffer. A bufRdEn pulse clears it.
- R9: If a byte completes while bufFull is still set, overflow is set and the buffer keeps its earlier byte.
- R10: A buffer write while a transfer is in progress sets wrCollision. The write is dropped and the running transfer continues unchanged.
- R11: With enable low, any transfer is aborted, SCK rests at idle, busy is low, and bufFull, overflow and wrCollision are cleared. Mode values 4'b0110 to 4'b1111 are inactive, and writes in those modes start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port run enable |
| modeSel | input | 4 | Role and master clock source |
| clkPol | input | 1 | SCK idle level |
| clkEdge | input | 1 | Launch/capture edge choice |
| cycTick | input | 1 | Instruction-cycle tick used by the master dividers |
| timerPulse | input | 1 | External timer pulse used as a master clock source |
| bufWrEn | input | 1 | Processor write strobe for the outgoing byte |
| bufWrData | input | 8 | Outgoing byte |
| bufRdEn | input | 1 | Processor read strobe, clears bufFull |
| bufRdData | output | 8 | Last received byte |
| bufFull | output | 1 | Received byte waiting |
| overflow | output | 1 | Byte completed while the buffer was full |
| wrCollision | output | 1 | Write attempted during a transfer |
| busy | output | 1 | Transfer in progress |
| sckIn | input | 1 | Serial clock input in slave mode |
| sckOut | output | 1 | Serial clock output |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ssN | input | 1 | Active-low slave select |

## Verification
The assertions assume that modeSel, clkPol and clkEdge change only while enable is low. They also assume that sckIn and ssN move slowly compared with the system clock, so that every SCK level lasts longer than the three-cycle synchroniser and edge-detect path. The bench follows both rules. Every change of configuration goes through a task that drops enable for several cycles, sets the new values and re-enables the port. The bench's model of the slave-side clock holds each SCK level for eight system cycles. Data on sdi is changed only on the edge opposite the capture edge, so each bit is stable for at least two cycles before the port samples it.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [3:0] MODE_DIV_A  = 4'b0000;
  localparam logic [3:0] MODE_DIV_B  = 4'b0001;
  localparam logic [3:0] MODE_DIV_C  = 4'b0010;
  localparam logic [3:0] MODE_TIMER  = 4'b0011;
  localparam logic [3:0] MODE_SL_SEL = 4'b0100;
  localparam logic [3:0] MODE_SL_ANY = 4'b0101;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;       // copy processor byte into the shifter
    logic launch;     // present next bit on SDO
    logic capture;    // shift SDI in
    logic commit;     // this capture completes the byte
    logic collide;    // write refused during a transfer
    logic clearFlags; // port disabled
  } dpStrobe_t;

endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [3:0] modeSel,
  input  logic       clkPol,
  input  logic       clkEdge,
  input  logic       cycTick,
  input  logic       timerPulse,
  input  logic       bufWrEn,
  input  logic       sckIn,
  input  logic       ssN,
  output dpStrobe_t  strb,
  output logic       sckOut,
  output logic       busyOut
);

  localparam int HALF_A  = DIV_A / 2;
  localparam int HALF_B  = DIV_B / 2;
  localparam int HALF_C  = DIV_C / 2;
  localparam int DIV_W   = $clog2(HALF_C + 1);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int PHASE_W = $clog2(2 * DATA_W);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(2 * DATA_W - 1);
  localparam logic [BIT_W-1:0]   BIT_LAST   = BIT_W'(DATA_W - 1);

  logic isMaster, isSlave, active, ssCtl, ssBlock;
  assign isMaster = (modeSel[3:2] == 2'b00);
  assign isSlave  = (modeSel == MODE_SL_SEL) || (modeSel == MODE_SL_ANY);
  assign active   = enable && (isMaster || isSlave);
  // edge=1 slave requires select control, so it is forced on
  assign ssCtl    = (modeSel == MODE_SL_SEL) || ((modeSel == MODE_SL_ANY) && clkEdge);
  assign ssBlock  = isSlave && ssCtl && ssN;

  // ---------------- master clock generation ----------------
  logic [DIV_W-1:0]   halfLim, divCnt;
  logic [PHASE_W-1:0] phaseCnt;
  logic mBusy, sckLvl, tickEvt, phaseEvt;

  always_comb begin
    case (modeSel)
      MODE_DIV_B: halfLim = DIV_W'(HALF_B);
      MODE_DIV_C: halfLim = DIV_W'(HALF_C);
      default:    halfLim = DIV_W'(HALF_A);
    endcase
  end

  assign tickEvt  = (modeSel == MODE_TIMER) ? timerPulse
                                            : (cycTick && (divCnt == halfLim - 1'b1));
  assign phaseEvt = mBusy && tickEvt;

  // ---------------- slave clock synchroniser ----------------
  logic [1:0] sckSync;
  logic sckPrev, sckChg, sckAct, slaveRun;
  assign sckChg   = sckSync[1] ^ sckPrev;
  assign sckAct   = sckSync[1] ^ clkPol;
  assign slaveRun = active && isSlave && !ssBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSync <= {sckSync[0], sckIn};
      sckPrev <= sckSync[1];
    end
  end

  // ---------------- edge selection ----------------
  logic lead, trail, launchEvt, captureEvt;
  logic [BIT_W-1:0] bitCnt;
  logic inXfer;

  always_comb begin
    if (isMaster) begin
      lead  = phaseEvt && !phaseCnt[0];
      trail = phaseEvt &&  phaseCnt[0];
    end else begin
      lead  = slaveRun && sckChg &&  sckAct;
      trail = slaveRun && sckChg && !sckAct;
    end
  end

  assign launchEvt  = clkEdge ? trail : lead;
  assign captureEvt = clkEdge ? lead  : trail;
  assign inXfer     = active && (isMaster ? mBusy : (bitCnt != '0));

  always_comb begin
    strb            = '0;
    strb.load       = active && bufWrEn && !inXfer;
    strb.collide    = active && bufWrEn &&  inXfer;
    strb.launch     = launchEvt;
    strb.capture    = captureEvt;
    strb.commit     = captureEvt && (bitCnt == BIT_LAST);
    strb.clearFlags = !enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy    <= 1'b0;
      divCnt   <= '0;
      phaseCnt <= '0;
      sckLvl   <= 1'b0;
      bitCnt   <= '0;
    end else if (!active) begin
      mBusy    <= 1'b0;
      divCnt   <= '0;
      phaseCnt <= '0;
      sckLvl   <= 1'b0;
      bitCnt   <= '0;
    end else begin
      if (isMaster) begin
        if (!mBusy) begin
          divCnt   <= '0;
          phaseCnt <= '0;
          sckLvl   <= 1'b0;
          if (strb.load) mBusy <= 1'b1;
        end else begin
          if (cycTick) divCnt <= (divCnt == halfLim - 1'b1) ? '0 : divCnt + 1'b1;
          if (phaseEvt) begin
            sckLvl   <= ~sckLvl;
            phaseCnt <= phaseCnt + 1'b1;
            if (phaseCnt == PHASE_LAST) mBusy <= 1'b0;
          end
        end
      end
      if (ssBlock) bitCnt <= '0;
      else if (captureEvt) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign sckOut  = clkPol ^ (isMaster && sckLvl);
  assign busyOut = inXfer;

  // R1: after the final trailing edge the clock is home and the port idle
  a_r1_sck_home: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mBusy && phaseEvt && phaseCnt == PHASE_LAST) |=> (!mBusy && sckOut == clkPol));

  // R2: timer-sourced clock moves only on a timer pulse
  a_r2_timer_paced: assert property (@(posedge clk) disable iff (!rstN)
    (enable && mBusy && modeSel == MODE_TIMER && !timerPulse) |=> $stable(sckOut));

  // R6: select high holds the slave bit counter at zero
  a_r6_select_reset: assert property (@(posedge clk) disable iff (!rstN)
    (enable && modeSel == MODE_SL_SEL && ssN) |=> (bitCnt == '0));

endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRdEn,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              overflow,
  output logic              wrCollision
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] nextShift;
  logic              sdoReg;

  assign nextShift = {shiftReg[DATA_W-2:0], sdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= bufWrData;
      sdoReg   <= bufWrData[DATA_W-1];
    end else if (strb.capture) begin
      shiftReg <= nextShift;
    end else if (strb.launch) begin
      sdoReg <= shiftReg[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData     <= '0;
      bufFull     <= 1'b0;
      overflow    <= 1'b0;
      wrCollision <= 1'b0;
    end else if (strb.clearFlags) begin
      bufFull     <= 1'b0;
      overflow    <= 1'b0;
      wrCollision <= 1'b0;
    end else begin
      if (strb.commit) begin
        if (!bufFull || bufRdEn) bufData <= nextShift;
        else                     overflow <= 1'b1;
        bufFull <= 1'b1;
      end else if (bufRdEn) begin
        bufFull <= 1'b0;
      end
      if (strb.collide) wrCollision <= 1'b1;
    end
  end

  assign sdo = sdoReg;

  // R8: a read with no byte arriving empties the buffer
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (bufRdEn && !strb.commit && !strb.clearFlags) |=> !bufFull);

  // R9: an overflowing byte leaves the held byte untouched
  a_r9_buffer_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && bufFull && !bufRdEn && !strb.clearFlags) |=> ($stable(bufData) && overflow));

  // R10: a refused write raises the collision flag
  a_r10_collision_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.collide && !strb.clearFlags) |=> wrCollision);

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [3:0]        modeSel,
  input  logic              clkPol,
  input  logic              clkEdge,
  input  logic              cycTick,
  input  logic              timerPulse,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRdEn,
  output logic [DATA_W-1:0] bufRdData,
  output logic              bufFull,
  output logic              overflow,
  output logic              wrCollision,
  output logic              busy,
  input  logic              sckIn,
  output logic              sckOut,
  input  logic              sdi,
  output logic              sdo,
  input  logic              ssN
);

  dpStrobe_t strb;

  spi_port_ctrl #(
    .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .modeSel   (modeSel),
    .clkPol    (clkPol),
    .clkEdge   (clkEdge),
    .cycTick   (cycTick),
    .timerPulse(timerPulse),
    .bufWrEn   (bufWrEn),
    .sckIn     (sckIn),
    .ssN       (ssN),
    .strb      (strb),
    .sckOut    (sckOut),
    .busyOut   (busy)
  );

  spi_port_dp #(
    .DATA_W(DATA_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bufWrData  (bufWrData),
    .bufRdEn    (bufRdEn),
    .sdi        (sdi),
    .sdo        (sdo),
    .bufData    (bufRdData),
    .bufFull    (bufFull),
    .overflow   (overflow),
    .wrCollision(wrCollision)
  );

endmodule

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [3:0] modeSel = 4'b0000;
  logic clkPol = 1'b0, clkEdge = 1'b0;
  logic cycTick = 1'b1, timerPulse = 1'b0;
  logic bufWrEn = 1'b0, bufRdEn = 1'b0;
  logic [7:0] bufWrData = 8'h00;
  logic [7:0] bufRdData;
  logic bufFull, overflow, wrCollision, busy;
  logic sckIn = 1'b0, sckOut, sdi = 1'b0, sdo, ssN = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_port i_spi_port (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .clkPol(clkPol), .clkEdge(clkEdge), .cycTick(cycTick), .timerPulse(timerPulse),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .bufRdEn(bufRdEn),
    .bufRdData(bufRdData), .bufFull(bufFull), .overflow(overflow),
    .wrCollision(wrCollision), .busy(busy), .sckIn(sckIn), .sckOut(sckOut),
    .sdi(sdi), .sdo(sdo), .ssN(ssN)
  );

  // free-running timer source: one pulse every 5 cycles
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      timerPulse = 1'b1;
      @(negedge clk);
      timerPulse = 1'b0;
    end
  end

  typedef struct packed {
    logic [3:0] mode;
    logic       pol;
    logic       edg;
    logic [7:0] tx;
    logic [7:0] rx;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0000, 1'b0, 1'b0, 8'hA5, 8'h3C},
    '{4'b0001, 1'b1, 1'b0, 8'h5A, 8'hC3},
    '{4'b0010, 1'b0, 1'b1, 8'h81, 8'h7E},
    '{4'b0011, 1'b1, 1'b1, 8'hF0, 8'h0F},
    '{4'b0100, 1'b0, 1'b0, 8'h96, 8'h69},
    '{4'b0100, 1'b1, 1'b1, 8'hE1, 8'h1E},
    '{4'b0101, 1'b0, 1'b0, 8'h33, 8'hCC},
    '{4'b0101, 1'b1, 1'b1, 8'h47, 8'hB8}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic setup(input logic [3:0] m, input logic pol, input logic edg);
    @(negedge clk);
    enable = 1'b0; modeSel = m; clkPol = pol; clkEdge = edg;
    sckIn = pol; ssN = 1'b1; sdi = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    bufWrEn = 1'b1; bufWrData = d;
    @(negedge clk);
    bufWrEn = 1'b0;
  endtask

  task automatic readByte();
    @(negedge clk);
    bufRdEn = 1'b1;
    @(negedge clk);
    bufRdEn = 1'b0;
  endtask

  // acts as the far-end slave while the port is master
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] rx, output logic [7:0] seen);
    seen = 8'h00;
    sdi = clkEdge ? rx[7] : 1'b0;
    writeByte(tx);
    for (int i = 0; i < 16; i++) begin
      int b;
      b = i / 2;
      @(sckOut);
      #1;
      if (sckOut != clkPol) begin
        seen[7-b] = sdo;
        if (!clkEdge) sdi = rx[7-b];
      end else if (clkEdge && b < 7) begin
        sdi = rx[6-b];
      end
    end
    repeat (2) @(negedge clk);
  endtask

  // acts as the far-end master while the port is slave
  task automatic slaveXfer(input logic [7:0] tx, input logic [7:0] rx, input logic selLvl,
                           output logic [7:0] seen);
    seen = 8'h00;
    @(negedge clk);
    ssN = selLvl;
    sdi = clkEdge ? rx[7] : 1'b0;
    writeByte(tx);
    repeat (4) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      if (clkEdge) seen[7-b] = sdo;
      sckIn = ~clkPol;
      if (!clkEdge) sdi = rx[7-b];
      repeat (8) @(negedge clk);
      if (!clkEdge) seen[7-b] = sdo;
      sckIn = clkPol;
      if (clkEdge && b < 7) sdi = rx[6-b];
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic measureHalf(output int n);
    logic lvl;
    @(sckOut);
    lvl = sckOut;
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (sckOut == lvl && n < 300);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    int n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 / R3: reset state
    check("R11 reset bufFull", bufFull, 0);
    check("R11 reset overflow", overflow, 0);
    check("R11 reset wrCollision", wrCollision, 0);
    check("R11 reset busy", busy, 0);
    check("R3 reset sck idle", sckOut, 0);

    // vector table: master rows R1 R2 R4, slave rows R5 R7
    for (int v = 0; v < NVEC; v++) begin
      setup(VECS[v].mode, VECS[v].pol, VECS[v].edg);
      if (VECS[v].mode[2]) slaveXfer(VECS[v].tx, VECS[v].rx, 1'b0, seen);
      else                 masterXfer(VECS[v].tx, VECS[v].rx, seen);
      @(negedge clk);
      check("R4 R5 sdo bit order", seen, VECS[v].tx);
      check("R1 R5 received byte", bufRdData, VECS[v].rx);
      check("R8 full after byte", bufFull, 1);
      check("R3 sck idle after byte", sckOut, VECS[v].pol);
      check("R1 not busy after byte", busy, 0);
      readByte();
      check("R8 read clears full", bufFull, 0);
    end

    // R2: divider and timer rates
    setup(4'b0000, 1'b0, 1'b0);
    writeByte(8'h00);
    measureHalf(n);
    check("R2 half period div4", n, 2);
    setup(4'b0001, 1'b0, 1'b0);
    writeByte(8'h00);
    measureHalf(n);
    check("R2 half period div16", n, 8);
    setup(4'b0010, 1'b0, 1'b0);
    writeByte(8'h00);
    measureHalf(n);
    check("R2 half period div64", n, 32);
    setup(4'b0011, 1'b0, 1'b0);
    writeByte(8'h00);
    measureHalf(n);
    check("R2 half period timer", n, 5);

    // R10: write during a master transfer
    setup(4'b0000, 1'b0, 1'b0);
    fork
      masterXfer(8'hC6, 8'h2B, seen);
      begin
        repeat (6) @(negedge clk);
        bufWrEn = 1'b1; bufWrData = 8'h00;
        @(negedge clk);
        bufWrEn = 1'b0;
      end
    join
    @(negedge clk);
    check("R10 collision flag", wrCollision, 1);
    check("R10 transfer unaffected tx", seen, 8'hC6);
    check("R10 transfer unaffected rx", bufRdData, 8'h2B);

    // R9: second byte without a read
    setup(4'b0000, 1'b0, 1'b0);
    masterXfer(8'h01, 8'h11, seen);
    masterXfer(8'h02, 8'h22, seen);
    @(negedge clk);
    check("R9 overflow set", overflow, 1);
    check("R9 buffer keeps first", bufRdData, 8'h11);

    // R11: disable clears the flags
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R11 disable clears overflow", overflow, 0);
    check("R11 disable clears full", bufFull, 0);

    // R11: disable mid-transfer
    setup(4'b0001, 1'b1, 1'b0);
    writeByte(8'hFF);
    repeat (12) @(negedge clk);
    check("R11 busy mid transfer", busy, 1);
    enable = 1'b0;
    @(negedge clk);
    check("R11 abort busy", busy, 0);
    check("R11 abort sck idle", sckOut, 1);

    // R11: inactive mode ignores writes
    setup(4'b1000, 1'b0, 1'b0);
    writeByte(8'h55);
    repeat (20) @(negedge clk);
    check("R11 inactive mode busy", busy, 0);
    check("R11 inactive mode sck", sckOut, 0);

    // R6: partial byte then select high
    setup(4'b0100, 1'b0, 1'b0);
    @(negedge clk);
    ssN = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      sckIn = 1'b1; sdi = 1'b1;
      repeat (8) @(negedge clk);
      sckIn = 1'b0;
      repeat (8) @(negedge clk);
    end
    ssN = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 partial byte discarded", bufFull, 0);
    slaveXfer(8'h0F, 8'h5C, 1'b0, seen);
    @(negedge clk);
    check("R6 next byte from bit7", bufRdData, 8'h5C);
    check("R6 next byte sdo", seen, 8'h0F);

    // R6: select high for a whole byte
    setup(4'b0100, 1'b0, 1'b0);
    slaveXfer(8'h00, 8'hAA, 1'b1, seen);
    @(negedge clk);
    check("R6 select high blocks byte", bufFull, 0);

    // R7: free-select slave ignores ssN with edge 0
    setup(4'b0101, 1'b0, 1'b0);
    slaveXfer(8'h00, 8'h9D, 1'b1, seen);
    @(negedge clk);
    check("R7 ssN ignored edge0", bufRdData, 8'h9D);
    check("R7 ssN ignored full", bufFull, 1);

    // R7: edge 1 forces select control
    setup(4'b0101, 1'b0, 1'b1);
    slaveXfer(8'h00, 8'h77, 1'b1, seen);
    @(negedge clk);
    check("R7 forced select blocks", bufFull, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule